// File: doc/BRIEF.md
# Warp Branch Lane-Mask Sequencer

This block owns the active-lane mask of a single 32-lane warp and walks it through one level of two-way branching. Every lane shares one instruction stream, so when the lanes disagree on a branch condition the two sides cannot run together. The block runs the side where the condition is true first, with every other lane masked. It then runs the other side with the first group masked. After that it puts back the mask that was in force before the branch. Lanes whose mask bit is clear still step through each instruction, but their write enables are held off by the mask this block drives.

A launch strobe carries a total thread count. The block rounds the count up to whole warps by ceiling division and reports that warp count. It builds the mask of the last, possibly partial, warp: lanes below the remainder are enabled and the rest are masked. A cumulative pass counter shows the cost of the branches. A divergent branch adds two passes. A branch on which all active lanes agree adds one, and the empty side is skipped entirely.

The branch condition enters through a valid/ready handshake. A branch transfers on a cycle where `br_valid` and `br_ready` are both high. `br_ready` is high only while no branch is being serialized and no launch is presented. The sender is not expected to hold a refused branch. A branch presented while a divergence is still in progress is dropped and flagged on `br_err`. A branch refused only because a launch arrives in the same cycle is dropped without the flag. Launch, path-end and all outputs are plain control and status pins.

Top module: `warp_div_serializer`

## Requirements
- R1: After reset, `active_mask` is 0, `path_sel` is 0 (no branch), `pass_count` is 0, `warp_count` is 0, `br_err` is 0 and `br_ready` is 1.
- R2: A launch with thread count N sets `warp_count` to ceil(N/32) on the next cycle. It sets the mask to lanes 0..r-1 with r = N mod 32, or all 32 lanes when N is a nonzero multiple of 32, or no lanes when N is 0. It also clears `pass_count`. Bit i of every mask is lane i.
- R3: An accepted branch where the active lanes disagree sets `active_mask` to (pre-branch mask AND cond) and `path_sel` to 1 (true side) on the next cycle, and adds 2 to `pass_count`.
- R4: A `path_end` pulse during the true side of a divergent branch switches `active_mask` to (pre-branch mask AND NOT cond) and `path_sel` to 2 (false side) on the next cycle.
- R5: A `path_end` pulse on the last side of a branch restores `active_mask` exactly to the pre-branch mask and sets `path_sel` to 0 on the next cycle.
- R6: An accepted branch where every active lane has cond 1 runs only the true side (`path_sel` 1). If every active lane has cond 0, or no lane is active, only the false side runs (`path_sel` 2). In both cases the mask stays at the pre-branch mask and `pass_count` rises by 1. Cond bits of masked lanes have no effect.
- R7: A branch presented while `path_sel` is nonzero raises `br_err` for exactly one cycle. It leaves the mask, `path_sel` and `pass_count` unchanged.
- R8: `br_ready` is 1 exactly when `path_sel` is 0 and `launch_valid` is 0. A `path_end` pulse while `path_sel` is 0 changes nothing.
- R9: While a path runs, `active_mask` contains no lane outside the pre-branch mask, and `pass_count` never rises by more than 2 per cycle.
- R10: A launch takes priority over everything else in its cycle and aborts any branch in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| launch_valid | input | 1 | Launch strobe |
| launch_threads | input | 16 | Total thread count for the launch |
| br_valid | input | 1 | Branch condition valid |
| br_ready | output | 1 | Branch can be accepted this cycle |
| br_cond | input | 32 | Per-lane branch condition, bit i is lane i |
| path_end | input | 1 | Current branch side has finished |
| active_mask | output | 32 | Lanes whose results are kept |
| path_sel | output | 2 | 0 no branch, 1 true side, 2 false side |
| pass_count | output | 16 | Passes spent on branches since launch |
| warp_count | output | 12 | Warps needed by the launched count |
| br_err | output | 1 | Branch dropped while serializing |

## Verification
All registered results (`active_mask`, `path_sel`, `pass_count`, `warp_count`, `br_err`) are due on the first rising edge after the input that causes them. The bench drives each stimulus 1 ns after a rising edge and compares the registered outputs 1 ns after the next one, so each compare sees exactly one edge of effect. `br_ready` depends on the current state and on `launch_valid` in the same cycle. It is therefore compared while the stimulus is still applied, before the edge. A bench model fed the same inputs gives the expected values at each step.

// File: rtl/dvs_pkg.sv
package dvs_pkg;
  typedef enum logic [1:0] {
    PATH_NONE  = 2'd0,
    PATH_TRUE  = 2'd1,
    PATH_FALSE = 2'd2
  } path_e;
endpackage

// File: rtl/dvs_launch_mask.sv
module dvs_launch_mask #(
  parameter int LANES = 32,
  parameter int CNT_W = 16,
  localparam int LANE_W = $clog2(LANES),
  localparam int WARP_W = CNT_W - LANE_W + 1
) (
  input  logic [CNT_W-1:0]  threads,
  output logic [LANES-1:0]  tail_mask,
  output logic [WARP_W-1:0] warps
);
  localparam int REM_W = LANE_W + 1;

  logic [CNT_W:0]      padded;
  logic [LANE_W-1:0]   rem;
  logic [REM_W-1:0]    tail_lanes;
  logic                none;

  always_comb begin
    padded     = {1'b0, threads} + (CNT_W+1)'(LANES - 1);
    warps      = WARP_W'(padded >> LANE_W);
    rem        = threads[LANE_W-1:0];
    none       = (threads == '0);
    tail_lanes = (rem == '0) ? REM_W'(LANES) : {1'b0, rem};
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign tail_mask[i] = !none && (REM_W'(i) < tail_lanes);
  end
endmodule

// File: rtl/dvs_lane_split.sv
module dvs_lane_split #(
  parameter int LANES = 32
) (
  input  logic [LANES-1:0] cur_mask,
  input  logic [LANES-1:0] cond,
  output logic [LANES-1:0] true_mask,
  output logic [LANES-1:0] false_mask,
  output logic             diverged,
  output logic             any_true
);
  always_comb begin
    true_mask  = cur_mask & cond;
    false_mask = cur_mask & ~cond;
    any_true   = |true_mask;
    diverged   = any_true && (|false_mask);
  end
endmodule

// File: rtl/dvs_pass_ctr.sv
module dvs_pass_ctr #(
  parameter int PASS_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              add_one,
  input  logic              add_two,
  output logic [PASS_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rst_n || clear) count <= '0;
    else if (add_two)    count <= count + PASS_W'(2);
    else if (add_one)    count <= count + PASS_W'(1);
  end
endmodule

// File: rtl/dvs_seq.sv
module dvs_seq
  import dvs_pkg::*;
#(
  parameter int LANES = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LANES-1:0] load_mask,
  input  logic             accept,
  input  logic [LANES-1:0] true_mask,
  input  logic [LANES-1:0] false_mask,
  input  logic             diverged,
  input  logic             any_true,
  input  logic             path_end,
  output logic [LANES-1:0] active_mask,
  output logic [LANES-1:0] saved_mask,
  output path_e            path,
  output logic             busy
);
  logic [LANES-1:0] second_q;
  logic             pending_q;

  assign busy = (path != PATH_NONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_mask <= '0;
      saved_mask  <= '0;
      second_q    <= '0;
      pending_q   <= 1'b0;
      path        <= PATH_NONE;
    end else if (load) begin
      active_mask <= load_mask;
      saved_mask  <= load_mask;
      second_q    <= '0;
      pending_q   <= 1'b0;
      path        <= PATH_NONE;
    end else if (busy && path_end) begin
      if (pending_q) begin
        active_mask <= second_q;
        pending_q   <= 1'b0;
        path        <= PATH_FALSE;
      end else begin
        active_mask <= saved_mask;
        path        <= PATH_NONE;
      end
    end else if (accept) begin
      saved_mask <= active_mask;
      second_q   <= false_mask;
      if (diverged) begin
        active_mask <= true_mask;
        pending_q   <= 1'b1;
        path        <= PATH_TRUE;
      end else begin
        pending_q <= 1'b0;
        path      <= any_true ? PATH_TRUE : PATH_FALSE;
      end
    end
  end
endmodule

// File: rtl/warp_div_serializer.sv
module warp_div_serializer
  import dvs_pkg::*;
#(
  parameter int LANES  = 32,
  parameter int CNT_W  = 16,
  parameter int PASS_W = 16,
  localparam int LANE_W = $clog2(LANES),
  localparam int WARP_W = CNT_W - LANE_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch_valid,
  input  logic [CNT_W-1:0]  launch_threads,
  input  logic              br_valid,
  output logic              br_ready,
  input  logic [LANES-1:0]  br_cond,
  input  logic              path_end,
  output logic [LANES-1:0]  active_mask,
  output logic [1:0]        path_sel,
  output logic [PASS_W-1:0] pass_count,
  output logic [WARP_W-1:0] warp_count,
  output logic              br_err
);
  logic [LANES-1:0]  tail_mask;
  logic [WARP_W-1:0] warps_calc;
  logic [LANES-1:0]  true_mask, false_mask, pre_mask;
  logic              diverged, any_true, busy, accept;
  path_e             path;

  dvs_launch_mask #(.LANES(LANES), .CNT_W(CNT_W)) u_launch (
    .threads(launch_threads), .tail_mask(tail_mask), .warps(warps_calc)
  );

  dvs_lane_split #(.LANES(LANES)) u_split (
    .cur_mask(active_mask), .cond(br_cond), .true_mask(true_mask),
    .false_mask(false_mask), .diverged(diverged), .any_true(any_true)
  );

  assign br_ready = !busy && !launch_valid;
  assign accept   = br_valid && br_ready;
  assign path_sel = path;

  dvs_seq #(.LANES(LANES)) u_seq (
    .clk(clk), .rst_n(rst_n), .load(launch_valid), .load_mask(tail_mask),
    .accept(accept), .true_mask(true_mask), .false_mask(false_mask),
    .diverged(diverged), .any_true(any_true), .path_end(path_end),
    .active_mask(active_mask), .saved_mask(pre_mask), .path(path), .busy(busy)
  );

  dvs_pass_ctr #(.PASS_W(PASS_W)) u_pass (
    .clk(clk), .rst_n(rst_n), .clear(launch_valid),
    .add_one(accept && !diverged), .add_two(accept && diverged),
    .count(pass_count)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      warp_count <= '0;
      br_err     <= 1'b0;
    end else begin
      if (launch_valid) warp_count <= warps_calc;
      br_err <= br_valid && busy && !launch_valid;
    end
  end
endmodule

// File: rtl/dvs_checker.sv
module dvs_checker #(
  parameter int LANES  = 32,
  parameter int PASS_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              launch_valid,
  input logic              br_valid,
  input logic              br_ready,
  input logic [LANES-1:0]  br_cond,
  input logic              path_end,
  input logic [LANES-1:0]  active_mask,
  input logic [LANES-1:0]  pre_mask,
  input logic [1:0]        path_sel,
  input logic [PASS_W-1:0] pass_count,
  input logic              br_err
);
  AST_DIV_TRUE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && br_ready && ((active_mask & br_cond) != '0) && ((active_mask & ~br_cond) != '0))
    |=> (path_sel == 2'd1 && active_mask == $past(active_mask & br_cond))); // R3

  AST_RESTORE_PRE: assert property (@(posedge clk) disable iff (!rst_n)
    (path_sel == 2'd2 && path_end && !launch_valid)
    |=> (path_sel == 2'd0 && active_mask == $past(pre_mask))); // R5

  AST_BUSY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && path_sel != 2'd0 && !launch_valid && !path_end)
    |=> (br_err && $stable(active_mask) && $stable(path_sel) && $stable(pass_count))); // R7

  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    br_ready |-> (path_sel == 2'd0 && !launch_valid)); // R8

  AST_MASK_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
    (path_sel != 2'd0) |-> ((active_mask & ~pre_mask) == '0)); // R9

  AST_PASS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !launch_valid |=> (PASS_W'(pass_count - $past(pass_count)) <= PASS_W'(2))); // R9

  AST_LAUNCH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    launch_valid |=> (path_sel == 2'd0 && pass_count == '0 && !br_err)); // R10
endmodule

bind warp_div_serializer dvs_checker #(.LANES(LANES), .PASS_W(PASS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .launch_valid(launch_valid), .br_valid(br_valid),
  .br_ready(br_ready), .br_cond(br_cond), .path_end(path_end),
  .active_mask(active_mask), .pre_mask(pre_mask), .path_sel(path_sel),
  .pass_count(pass_count), .br_err(br_err)
);

// File: tb/warp_div_serializer_test.sv
`timescale 1ns/1ps
module warp_div_serializer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        launch_valid = 1'b0;
  logic [15:0] launch_threads = '0;
  logic        br_valid = 1'b0;
  logic        br_ready;
  logic [31:0] br_cond = '0;
  logic        path_end = 1'b0;
  logic [31:0] active_mask;
  logic [1:0]  path_sel;
  logic [15:0] pass_count;
  logic [11:0] warp_count;
  logic        br_err;

  int n_checks = 0;
  int n_fail   = 0;

  // bench model
  logic [31:0] m_mask = '0, m_pre = '0, m_second = '0;
  logic [1:0]  m_path = '0;
  logic        m_pend = 1'b0, m_err = 1'b0;
  logic [15:0] m_pass = '0;
  logic [11:0] m_warps = '0;

  always #2 clk = ~clk;

  warp_div_serializer uut (
    .clk(clk), .rst_n(rst_n), .launch_valid(launch_valid),
    .launch_threads(launch_threads), .br_valid(br_valid), .br_ready(br_ready),
    .br_cond(br_cond), .path_end(path_end), .active_mask(active_mask),
    .path_sel(path_sel), .pass_count(pass_count), .warp_count(warp_count),
    .br_err(br_err)
  );

  function automatic logic [11:0] f_warps(input int n);
    return 12'((n + 31) / 32);
  endfunction

  function automatic logic [31:0] f_tail(input int n);
    int r;
    if (n == 0) return 32'd0;
    r = n % 32;
    if (r == 0) return 32'hFFFF_FFFF;
    return (32'd1 << r) - 32'd1;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    chk(req, "active_mask", active_mask, m_mask);
    chk(req, "path_sel", 32'(path_sel), 32'(m_path));
    chk(req, "pass_count", 32'(pass_count), 32'(m_pass));
    chk(req, "warp_count", 32'(warp_count), 32'(m_warps));
    chk(req, "br_err", 32'(br_err), 32'(m_err));
  endtask

  task automatic model_step(input logic lv, input int n, input logic bv, input logic [31:0] c, input logic pe);
    logic busy;
    logic [31:0] t, f;
    busy  = (m_path != 2'd0);
    m_err = 1'b0;
    if (lv) begin
      m_mask = f_tail(n); m_pre = m_mask; m_path = 2'd0; m_pend = 1'b0;
      m_pass = '0; m_warps = f_warps(n);
    end else begin
      if (bv && busy) m_err = 1'b1;
      if (pe && busy) begin
        if (m_pend) begin m_mask = m_second; m_path = 2'd2; m_pend = 1'b0; end
        else begin m_mask = m_pre; m_path = 2'd0; end
      end else if (bv && !busy) begin
        t = m_mask & c; f = m_mask & ~c;
        m_pre = m_mask; m_second = f;
        if (t != 0 && f != 0) begin m_mask = t; m_path = 2'd1; m_pend = 1'b1; m_pass += 16'd2; end
        else begin m_path = (t != 0) ? 2'd1 : 2'd2; m_pend = 1'b0; m_pass += 16'd1; end
      end
    end
  endtask

  // drive one cycle, check ready before edge, outputs after edge
  task automatic step(input string req, input logic lv, input int n, input logic bv,
                      input logic [31:0] c, input logic pe);
    launch_valid = lv; launch_threads = 16'(n); br_valid = bv; br_cond = c; path_end = pe;
    #0.5;
    chk("R8", "br_ready", 32'(br_ready), 32'((m_path == 2'd0) && !lv));
    model_step(lv, n, bv, c, pe);
    @(posedge clk); #1;
    launch_valid = 1'b0; br_valid = 1'b0; path_end = 1'b0;
    chk_all(req);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    process::self().srandom(32'd7);
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk_all("R1");
    chk("R1", "br_ready", 32'(br_ready), 32'd1);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk_all("R1");

    // R8 path_end while idle ignored
    step("R8", 0, 0, 0, '0, 1);
    // R6 branch with no lanes active -> false side only
    step("R6", 0, 0, 1, 32'hFFFF_FFFF, 0);
    step("R5", 0, 0, 0, '0, 1);

    // R2 launch shapes
    step("R2", 1, 100, 0, '0, 0);
    chk("R2", "100 threads tail mask", active_mask, 32'h0000_000F);
    step("R2", 1, 33, 0, '0, 0);
    step("R2", 1, 0, 0, '0, 0);
    step("R2", 1, 64, 0, '0, 0);
    chk("R2", "64 threads full warp", active_mask, 32'hFFFF_FFFF);
    step("R2", 1, 65535, 0, '0, 0);

    // R3/R4/R5 divergent even/odd
    step("R2", 1, 128, 0, '0, 0);
    step("R3", 0, 0, 1, 32'h5555_5555, 0);
    step("R7", 0, 0, 1, 32'h0000_FFFF, 0);   // busy branch dropped
    step("R7", 0, 0, 0, '0, 0);              // err lasts one cycle
    step("R4", 0, 0, 0, '0, 1);
    step("R5", 0, 0, 0, '0, 1);
    // R6 uniform true, and masked lanes disagreeing
    step("R6", 0, 0, 1, 32'hFFFF_FFFF, 0);
    step("R5", 0, 0, 0, '0, 1);
    step("R2", 1, 100, 0, '0, 0);
    step("R6", 0, 0, 1, 32'hFFFF_FFF0, 0);
    chk("R6", "false side keeps mask", active_mask, 32'h0000_000F);
    step("R7", 0, 0, 1, 32'h1, 1);           // busy branch with end: end still acts
    step("R6", 0, 0, 1, 32'h0000_000F, 0);
    step("R5", 0, 0, 0, '0, 1);
    // R10 launch aborts divergence, and wins over a branch
    step("R3", 0, 0, 1, 32'h0000_0005, 0);
    step("R10", 1, 40, 1, 32'h1, 1);
    step("R10", 1, 32, 1, 32'h1, 0);

    // random mix
    for (int k = 0; k < 4000; k++) begin
      int sel;
      logic [31:0] c;
      sel = int'($urandom_range(0, 99));
      c = $urandom();
      if ($urandom_range(0, 7) == 0) c = '0;
      else if ($urandom_range(0, 7) == 0) c = 32'hFFFF_FFFF;
      if (sel < 4)
        step("R10", 1, int'($urandom_range(0, 300)), $urandom_range(0, 1) == 1, c, $urandom_range(0, 1) == 1);
      else if (sel < 45)
        step("R3", 0, 0, 1, c, $urandom_range(0, 3) == 0);
      else if (sel < 90)
        step("R4", 0, 0, 0, c, 1);
      else
        step("R9", 0, 0, 0, c, 0);
      if ((m_path != 2'd0) && ((active_mask & ~m_pre) != 0)) begin
        n_checks++; n_fail++;
        $display("FAIL R9 mask outside pre-branch actual=%h expected_within=%h", active_mask, m_pre);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule